// File: doc/BRIEF.md
# Producer-consumer rendezvous synchronizer

This block sits in front of a small word-addressed memory and lets two hardware threads hand one value across at a shared word. Each word has an ownership bit. A claimed word does not hold data. It holds the identifier of the thread that claimed it and is now asleep. Whichever side reaches the word first claims it and is told to suspend. When the partner arrives, the value changes hands, the word is released holding that value, and a wake output names the sleeping thread so that a scheduler can resume it.

A producer that arrives first cannot leave its value in the word, because the word holds its identifier. The value is parked in a side buffer that has one slot per thread identifier. A consumer that arrives first needs nothing parked: the producer that follows supplies the value directly. If a second access of the same kind as the sleeper reaches a claimed word, it is turned away with a retry and leaves all state as it was. Plain reads and writes pass through to free words and are refused on claimed ones.

The block accepts one request per clock with no back-pressure. It answers every request exactly one cycle later.

Top module: `rdv_sync`

## Requirements
- R1: After synchronous active-low reset, rsp_valid and wake_valid are low, every ownership bit is clear and every word reads as zero.
- R2: A rendezvous store (req_op=2) to a free word is answered with a suspend (rsp_kind=1, rsp_data=0). The word is then claimed and holds the producer's identifier in its low bits.
- R3: A rendezvous load (req_op=3) to a word claimed by a waiting producer is answered with done (rsp_kind=0) and the producer's parked value in rsp_data. In the same cycle, wake_valid is high, wake_tid is the producer and wake_data is that value.
- R4: A rendezvous load to a free word is answered with a suspend and rsp_data=0. The word is then claimed by that consumer.
- R5: A rendezvous store to a word claimed by a waiting consumer is answered with done and the store data in rsp_data. In the same cycle, the consumer is woken with wake_data equal to the store data.
- R6: A rendezvous access of the same kind as the sleeping owner is answered with retry (rsp_kind=2, rsp_data=0) and changes nothing. A later opposite access still completes with the original owner and the original value.
- R7: After a completed handoff, the word's ownership bit is clear and the word holds the transferred value.
- R8: A plain read (req_op=0) of a free word returns done with the word's contents. A plain write (req_op=1) to a free word stores req_data and returns done with that data. Either plain access to a claimed word returns retry and changes nothing.
- R9: Every request gets exactly one response, in the cycle after it is taken, with rsp_tid equal to the request's thread identifier. wake_valid is high only together with a done response.
- R10: Values parked by different producers on different words stay separate, and each goes to its own consumer in any completion order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 plain read, 1 plain write, 2 rendezvous store, 3 rendezvous load |
| req_addr | input | ADDR_W | Word address |
| req_tid | input | TID_W | Requesting thread identifier |
| req_data | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | 0 done, 1 suspend, 2 retry |
| rsp_tid | output | TID_W | Thread the response belongs to |
| rsp_data | output | DATA_W | Returned or transferred value |
| wake_valid | output | 1 | A sleeping thread is to resume |
| wake_tid | output | TID_W | Thread to resume |
| wake_data | output | DATA_W | Value handed over in the rendezvous |

## Verification
The bench tests both arrival orders and checks that the woken thread is the stored owner and not the requester, and that the value comes from the parked slot and not from the owner pointer. It sends same-kind second arrivals and plain accesses to claimed words, then completes the handoff. A design that let those requests overwrite the owner pointer or the parked value would wake the wrong thread or deliver the wrong data. Two producers park on different words and are drained in reverse order, which exposes a side buffer indexed by the wrong identifier. Back-to-back requests check the one-cycle response timing and that an idle cycle produces no response.

// File: rtl/rdv_pkg.sv
// Shared encodings for the rendezvous synchronizer.
// Assumes: request and response codes are the 2-bit values listed in the brief.
package rdv_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_RSTORE = 2'd2,
        OP_RLOAD  = 2'd3
    } rdv_op_e;

    typedef enum logic [1:0] {
        RSP_DONE    = 2'd0,
        RSP_SUSPEND = 2'd1,
        RSP_RETRY   = 2'd2
    } rdv_rsp_e;

    // Which side is asleep on a claimed word.
    localparam logic HOLD_PROD = 1'b0;
    localparam logic HOLD_CONS = 1'b1;

endpackage

// File: rtl/rdv_word_store.sv
// Word array with one ownership bit and one sleeper-kind bit per word.
// One combinational read port and one synchronous write port that updates
// word, ownership and kind together. Also exposes all ownership bits.
// Assumes: at most one write per cycle; synchronous active-low reset clears all.
module rdv_word_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output logic              rd_own,
    output logic              rd_hold,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              wr_own,
    input  logic              wr_hold,
    output logic [(1<<ADDR_W)-1:0] own_vec
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];
    logic [DEPTH-1:0]  hold_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // Update one entry when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[i]    <= '0;
                own_vec[i]  <= 1'b0;
                hold_vec[i] <= 1'b0;
            end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
                words[i]    <= wr_word;
                own_vec[i]  <= wr_own;
                hold_vec[i] <= wr_hold;
            end
        end
    end

    // Read the addressed entry.
    always_comb begin
        rd_word = words[rd_addr];
        rd_own  = own_vec[rd_addr];
        rd_hold = hold_vec[rd_addr];
    end

endmodule

// File: rtl/rdv_pend_buf.sv
// Side buffer with one slot per thread identifier, holding a producer's
// value while the claimed word holds that producer's identifier.
// Assumes: a thread has at most one parked value at a time.
module rdv_pend_buf #(
    parameter int TID_W  = 3,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TID_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TID_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SLOTS = 1 << TID_W;

    logic [DATA_W-1:0] slot [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        // Park a producer's value in its own slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[i] <= '0;
            else if (wr_en && (wr_idx == TID_W'(i)))
                slot[i] <= wr_data;
        end
    end

    // Fetch the slot of the current owner.
    always_comb rd_data = slot[rd_idx];

endmodule

// File: rtl/rdv_decide.sv
// Combinational rendezvous decision for one request. From the addressed
// word's state it picks the response, the word update, the parking write
// and the wake.
// Assumes: the owner identifier sits in the low TID_W bits of a claimed word.
module rdv_decide
    import rdv_pkg::*;
#(
    parameter int TID_W  = 3,
    parameter int DATA_W = 64
) (
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [DATA_W-1:0] req_data,
    input  logic [DATA_W-1:0] cur_word,
    input  logic              cur_own,
    input  logic              cur_hold,
    input  logic [DATA_W-1:0] pend_val,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_data,
    output logic              wake_en,
    output logic [TID_W-1:0]  wake_tid,
    output logic [DATA_W-1:0] wake_data,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_word,
    output logic              mem_own,
    output logic              mem_hold,
    output logic              pend_we
);
    localparam int PAD_W = DATA_W - TID_W;

    logic [DATA_W-1:0] ptr_word;

    // Owner pointer written into a word being claimed.
    always_comb ptr_word = {{PAD_W{1'b0}}, req_tid};

    // Choose the outcome of the request against the word's ownership state.
    always_comb begin
        rsp_kind  = RSP_DONE;
        rsp_data  = '0;
        wake_en   = 1'b0;
        wake_tid  = cur_word[TID_W-1:0];
        wake_data = '0;
        mem_we    = 1'b0;
        mem_word  = cur_word;
        mem_own   = 1'b0;
        mem_hold  = HOLD_PROD;
        pend_we   = 1'b0;
        if (req_valid) begin
            case (rdv_op_e'(req_op))
                OP_READ: begin
                    if (cur_own) rsp_kind = RSP_RETRY;
                    else         rsp_data = cur_word;
                end
                OP_WRITE: begin
                    if (cur_own) begin
                        rsp_kind = RSP_RETRY;
                    end else begin
                        mem_we   = 1'b1;
                        mem_word = req_data;
                        rsp_data = req_data;
                    end
                end
                OP_RSTORE: begin
                    if (!cur_own) begin
                        mem_we   = 1'b1;
                        mem_word = ptr_word;
                        mem_own  = 1'b1;
                        mem_hold = HOLD_PROD;
                        pend_we  = 1'b1;
                        rsp_kind = RSP_SUSPEND;
                    end else if (cur_hold == HOLD_CONS) begin
                        mem_we    = 1'b1;
                        mem_word  = req_data;
                        rsp_data  = req_data;
                        wake_en   = 1'b1;
                        wake_data = req_data;
                    end else begin
                        rsp_kind = RSP_RETRY;
                    end
                end
                default: begin
                    if (!cur_own) begin
                        mem_we   = 1'b1;
                        mem_word = ptr_word;
                        mem_own  = 1'b1;
                        mem_hold = HOLD_CONS;
                        rsp_kind = RSP_SUSPEND;
                    end else if (cur_hold == HOLD_PROD) begin
                        mem_we    = 1'b1;
                        mem_word  = pend_val;
                        rsp_data  = pend_val;
                        wake_en   = 1'b1;
                        wake_data = pend_val;
                    end else begin
                        rsp_kind = RSP_RETRY;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/rdv_sync.sv
// Rendezvous synchronizer top. Decides each request against the addressed
// word's ownership state, updates word and side buffer, and registers the
// response and wake one cycle after the request.
// Assumes: one request per cycle, never stalled; synchronous active-low reset.
module rdv_sync
    import rdv_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 64,
    parameter int TID_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [TID_W-1:0]  rsp_tid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              wake_valid,
    output logic [TID_W-1:0]  wake_tid,
    output logic [DATA_W-1:0] wake_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cur_word, pend_val, mem_word, dec_data, dec_wdata;
    logic              cur_own, cur_hold, mem_we, mem_own, mem_hold, pend_we, dec_wake;
    logic [1:0]        dec_kind;
    logic [TID_W-1:0]  dec_wtid;
    logic [DEPTH-1:0]  own_vec;
    logic [ADDR_W-1:0] rsp_addr_q;

    rdv_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(req_addr), .rd_word(cur_word), .rd_own(cur_own), .rd_hold(cur_hold),
        .wr_en(mem_we), .wr_addr(req_addr), .wr_word(mem_word),
        .wr_own(mem_own), .wr_hold(mem_hold), .own_vec(own_vec)
    );

    rdv_pend_buf #(.TID_W(TID_W), .DATA_W(DATA_W)) pend_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(pend_we), .wr_idx(req_tid), .wr_data(req_data),
        .rd_idx(cur_word[TID_W-1:0]), .rd_data(pend_val)
    );

    rdv_decide #(.TID_W(TID_W), .DATA_W(DATA_W)) decide_i (
        .req_valid(req_valid), .req_op(req_op), .req_tid(req_tid), .req_data(req_data),
        .cur_word(cur_word), .cur_own(cur_own), .cur_hold(cur_hold), .pend_val(pend_val),
        .rsp_kind(dec_kind), .rsp_data(dec_data),
        .wake_en(dec_wake), .wake_tid(dec_wtid), .wake_data(dec_wdata),
        .mem_we(mem_we), .mem_word(mem_word), .mem_own(mem_own), .mem_hold(mem_hold),
        .pend_we(pend_we)
    );

    // Register the response and wake one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_kind   <= RSP_DONE;
            rsp_tid    <= '0;
            rsp_data   <= '0;
            rsp_addr_q <= '0;
            wake_valid <= 1'b0;
            wake_tid   <= '0;
            wake_data  <= '0;
        end else begin
            rsp_valid  <= req_valid;
            wake_valid <= dec_wake;
            if (req_valid) begin
                rsp_kind   <= dec_kind;
                rsp_tid    <= req_tid;
                rsp_data   <= dec_data;
                rsp_addr_q <= req_addr;
            end
            if (dec_wake) begin
                wake_tid  <= dec_wtid;
                wake_data <= dec_wdata;
            end
        end
    end

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);  // R9
    AST_WAKE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> (rsp_valid && rsp_kind == RSP_DONE));  // R9
    AST_SUSPEND_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RSP_SUSPEND) |-> own_vec[rsp_addr_q]);  // R2
    AST_HANDOFF_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> !own_vec[rsp_addr_q]);  // R7
    AST_RETRY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RSP_RETRY) |-> $stable(own_vec));  // R6
    AST_WAKE_DATA_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> (wake_data == rsp_data));  // R3

endmodule

// File: tb/rdv_sync_tb_top.sv
// Scoreboard bench: the driver queues expected responses, the monitor
// compares each response against the queue head.
module rdv_sync_tb_top;
    localparam int AW = 4;
    localparam int DW = 64;
    localparam int TW = 3;
    localparam int K_DONE = 0, K_SUSP = 1, K_RETRY = 2;
    localparam int O_RD = 0, O_WR = 1, O_RST = 2, O_RLD = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [TW-1:0] req_tid = '0;
    logic [DW-1:0] req_data = '0;
    logic          rsp_valid, wake_valid;
    logic [1:0]    rsp_kind;
    logic [TW-1:0] rsp_tid, wake_tid;
    logic [DW-1:0] rsp_data, wake_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0]    kind;
        logic [TW-1:0] tid;
        logic [DW-1:0] data;
        logic          wake;
        logic [TW-1:0] wtid;
        logic [DW-1:0] wdata;
        string         tag;
    } exp_t;
    exp_t expq[$];

    always #4 clk = ~clk;

    rdv_sync #(.ADDR_W(AW), .DATA_W(DW), .TID_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_tid(req_tid), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_tid(rsp_tid), .rsp_data(rsp_data),
        .wake_valid(wake_valid), .wake_tid(wake_tid), .wake_data(wake_data)
    );

    // Drive one request and queue what must come back.
    task automatic send(input int op, input int addr, input int tid, input logic [DW-1:0] data,
                        input int ekind, input logic [DW-1:0] edata,
                        input bit ewake, input int ewtid, input logic [DW-1:0] ewdata,
                        input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op[1:0];
        req_addr  = addr[AW-1:0];
        req_tid   = tid[TW-1:0];
        req_data  = data;
        e.kind = ekind[1:0]; e.tid = tid[TW-1:0]; e.data = edata;
        e.wake = ewake; e.wtid = ewtid[TW-1:0]; e.wdata = ewdata; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: compare each response with the queue head.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (wake_valid && !rsp_valid) begin
                n_checks++; n_fail++;
                $display("FAIL R9: wake without response (wake_valid=%0d expected 0)", wake_valid);
            end
            if (rsp_valid) begin
                n_checks++;
                if (expq.size() == 0) begin
                    n_fail++;
                    $display("FAIL R9: response kind=%0d with nothing expected", rsp_kind);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    if (rsp_kind !== e.kind || rsp_tid !== e.tid || rsp_data !== e.data ||
                        wake_valid !== e.wake ||
                        (e.wake && (wake_tid !== e.wtid || wake_data !== e.wdata))) begin
                        n_fail++;
                        $display("FAIL %s: got kind=%0d tid=%0d data=%0h wake=%0d wtid=%0d wdata=%0h, expected kind=%0d tid=%0d data=%0h wake=%0d wtid=%0d wdata=%0h",
                                 e.tag, rsp_kind, rsp_tid, rsp_data, wake_valid, wake_tid, wake_data,
                                 e.kind, e.tid, e.data, e.wake, e.wtid, e.wdata);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish (expected completion)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the outputs
        n_checks++;
        if (rsp_valid !== 1'b0 || wake_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: rsp_valid=%0d wake_valid=%0d expected 0 0", rsp_valid, wake_valid);
        end
        send(O_RD, 5, 0, 0, K_DONE, 0, 0, 0, 0, "R1 word zero");
        send(O_RD, 3, 0, 0, K_DONE, 0, 0, 0, 0, "R1 word zero");
        // R8: plain pass-through
        send(O_WR, 2, 1, 64'hA5A5_0000_1111_2222, K_DONE, 64'hA5A5_0000_1111_2222, 0, 0, 0, "R8 write");
        send(O_RD, 2, 1, 0, K_DONE, 64'hA5A5_0000_1111_2222, 0, 0, 0, "R8 read");
        // R2/R3: producer first
        send(O_RST, 3, 1, 64'h42, K_SUSP, 0, 0, 0, 0, "R2 store suspends");
        send(O_RD, 3, 6, 0, K_RETRY, 0, 0, 0, 0, "R8 read claimed");
        send(O_WR, 3, 6, 64'hDEAD, K_RETRY, 0, 0, 0, 0, "R8 write claimed");
        send(O_RST, 3, 2, 64'h99, K_RETRY, 0, 0, 0, 0, "R6 store on store");
        send(O_RLD, 3, 4, 0, K_DONE, 64'h42, 1, 1, 64'h42, "R3 load wakes producer");
        send(O_RD, 3, 4, 0, K_DONE, 64'h42, 0, 0, 0, "R7 word holds value");
        // R4/R5: consumer first
        send(O_RLD, 7, 5, 0, K_SUSP, 0, 0, 0, 0, "R4 load suspends");
        send(O_RLD, 7, 6, 0, K_RETRY, 0, 0, 0, 0, "R6 load on load");
        idle(2);
        send(O_RST, 7, 0, 64'h1234_5678, K_DONE, 64'h1234_5678, 1, 5, 64'h1234_5678, "R5 store wakes consumer");
        send(O_RD, 7, 0, 0, K_DONE, 64'h1234_5678, 0, 0, 0, "R7 word holds value");
        // R10: two producers parked, drained in reverse order
        send(O_RST, 8, 2, 64'hAAAA, K_SUSP, 0, 0, 0, 0, "R10 park a");
        send(O_RST, 9, 3, 64'hBBBB, K_SUSP, 0, 0, 0, 0, "R10 park b");
        send(O_RLD, 9, 0, 0, K_DONE, 64'hBBBB, 1, 3, 64'hBBBB, "R10 drain b");
        send(O_RLD, 8, 1, 0, K_DONE, 64'hAAAA, 1, 2, 64'hAAAA, "R10 drain a");
        send(O_RD, 8, 1, 0, K_DONE, 64'hAAAA, 0, 0, 0, "R7 word a");
        send(O_RD, 9, 1, 0, K_DONE, 64'hBBBB, 0, 0, 0, "R7 word b");
        // R2: the word freed by a handoff can be claimed again
        send(O_RLD, 3, 7, 0, K_SUSP, 0, 0, 0, 0, "R4 reclaim");
        send(O_RST, 3, 6, 64'h77, K_DONE, 64'h77, 1, 7, 64'h77, "R5 reclaim handoff");
        idle(4);
        // R9: every request answered
        n_checks++;
        if (expq.size() != 0) begin
            n_fail++;
            $display("FAIL R9: %0d responses missing, expected 0", expq.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule